// File: doc/BRIEF.md
# DAC Sample Queue with Per-Sample Channel Routing

This block sits on the write side of a digital-to-analog converter controller. Software writes 32-bit values into a conversion-data register. The block turns each write into one or two queued 16-bit entries, depending on the transfer mode. With the half-word transfer mode, only the low half of a write is kept. With the word transfer mode, both halves are kept, and the low half is queued first. The queue holds four entries by default.

Each queued entry is reduced to a 12-bit sample and a 2-bit target channel. The channel comes from a configured default when tagging is off. When tagging is on, it comes from two tag bits inside each half-word. The channel is fixed when the entry is pushed, so later configuration changes do not reroute samples that are already waiting.

A ready flag tells the writer when a new write fits. The conversion sequencer drains the queue through a show-ahead pop port. That port presents the sample and its channel together while the queue is non-empty.

Top module: `dac_wr_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty: `pop_valid` is 0, and `wr_ready` is 1 while `cfg_enable` is 1.
- R2: With `cfg_word` = 0, each accepted write adds exactly one entry, whose sample is `wr_data[11:0]`; bits 31:16 of the write add nothing.
- R3: With `cfg_word` = 1, each accepted write adds two entries: first the one built from `wr_data[15:0]` (sample `wr_data[11:0]`), then the one built from `wr_data[31:16]` (sample `wr_data[27:16]`).
- R4: With `cfg_tag` = 0, every entry's channel equals `cfg_chan`, and the tag bits 13:12 of a half-word have no effect on the channel.
- R5: With `cfg_tag` = 1, an entry's channel is bits 13:12 of its own half-word: `wr_data[13:12]` for the first entry of a write and `wr_data[29:28]` for the second.
- R6: Entries leave in the order they entered. `wr_ready` is 0 when the queue holds DEPTH entries in half-word mode, and 1 when at least one slot is free.
- R7: With `cfg_word` = 1, `wr_ready` is 1 only if at least two slots are free. With DEPTH = 4, it is 0 at three stored entries and 1 at two.
- R8: `wr_ready` is 0 while `cfg_enable` is 0. A write presented while `wr_ready` is 0 leaves the queue contents and occupancy unchanged.
- R9: An entry's channel is resolved when the entry is pushed. Changing `cfg_chan` or `cfg_tag` afterwards does not alter the channel popped for it.
- R10: `pop_valid` is 1 exactly when the queue holds an entry. A pop on an empty queue has no effect. A push and a pop in the same cycle together leave the occupancy correct and the order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Controller can take conversion requests |
| cfg_word | input | 1 | 1 = word transfers (two entries per write), 0 = half-word transfers |
| cfg_tag | input | 1 | 1 = channel taken from tag bits 13:12 of each half-word |
| cfg_chan | input | CHAN_W (2) | Default channel used when tagging is off |
| wr_en | input | 1 | Write strobe for the conversion-data register |
| wr_data | input | 2*HALF_W (32) | Written data |
| wr_ready | output | 1 | A write presented now will be stored |
| pop_en | input | 1 | Sequencer removes the head entry |
| pop_valid | output | 1 | Head entry is present |
| pop_sample | output | SAMPLE_W (12) | Sample value of the head entry |
| pop_chan | output | CHAN_W (2) | Resolved channel of the head entry |

## Verification
The bench builds the block with its defaults: DEPTH 4, 12-bit samples, 2-bit channels and 16-bit halves. With these values the full point is reached in four half-word writes. The word-mode cutoff, at three stored entries, is reached by mixing one half-word write with one word write. The exact-fit case of two free slots, which must keep word-mode writes open, arises after a single word write. The small depth also makes a dropped write show up at once, as an extra or a missing entry when the queue is drained. It lets a pop on the empty queue be exposed as a wrapped occupancy.

// File: rtl/dac_wr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the DAC write-side queue.
package dac_wr_pkg;
  // Half-words carried by one register write.
  parameter int unsigned LANES = 2;

  // Transfer width selection.
  typedef enum logic {
    XFER_HALF = 1'b0,
    XFER_WORD = 1'b1
  } xfer_e;
endpackage

// File: rtl/dac_wr_split.sv
`timescale 1ns/1ps
// Splits one register write into LANES candidate entries and resolves
// each entry's channel from either the default or its own tag bits.
module dac_wr_split #(
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CHAN_W   = 2,
  parameter int unsigned TAG_LSB  = 12,
  parameter int unsigned LANES    = 2,
  parameter int unsigned ENT_W    = CHAN_W + SAMPLE_W
) (
  input  logic [LANES*HALF_W-1:0] wr_data,
  input  logic                    tag_mode,
  input  logic [CHAN_W-1:0]       def_chan,
  output logic [LANES*ENT_W-1:0]  entries
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HALF_W-1:0] half;
    logic [CHAN_W-1:0] chan;
    logic              lane_unused;

    assign half = wr_data[g*HALF_W +: HALF_W];
    // Tag bits sit above the sample field inside each half-word.
    assign chan = tag_mode ? half[TAG_LSB +: CHAN_W] : def_chan;
    assign entries[g*ENT_W +: ENT_W] = {chan, half[SAMPLE_W-1:0]};
    // Bits above the tag field carry no meaning.
    assign lane_unused = ^half;
  end

endmodule

// File: rtl/dac_wr_store.sv
`timescale 1ns/1ps
// Circular entry store that accepts zero, one or two entries per cycle
// and releases one entry per cycle from a show-ahead head.
module dac_wr_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ENT_W = 14,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       push_n,
  input  logic [ENT_W-1:0] push_lo,
  input  logic [ENT_W-1:0] push_hi,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic [CNT_W-1:0] level,
  output logic             nonempty_q,
  output logic             room1_q,
  output logic             room2_q
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W-1:0] wr_ptr_p1, wr_ptr_p2, rd_ptr_p1;
  logic [CNT_W-1:0] level_n;
  logic             pop_go;
  logic             room1_n, room2_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_ptr_p1 = bump(wr_ptr);
  assign wr_ptr_p2 = bump(wr_ptr_p1);
  assign rd_ptr_p1 = bump(rd_ptr);
  assign pop_go    = pop & nonempty_q;

  // Storage: no reset, plain indexed writes.
  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wr_ptr] <= push_lo;
    if (push_n == 2'd2) mem[wr_ptr_p1] <= push_hi;
  end

  assign head = mem[rd_ptr];

  always_comb begin
    level_n = level + CNT_W'(push_n) - CNT_W'(pop_go);
    room1_n = int'(level_n) < int'(DEPTH);
    room2_n = int'(level_n) + 2 <= int'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      level      <= '0;
      nonempty_q <= 1'b0;
      room1_q    <= 1'b1;
      room2_q    <= (DEPTH >= 2);
    end else begin
      case (push_n)
        2'd1:    wr_ptr <= wr_ptr_p1;
        2'd2:    wr_ptr <= wr_ptr_p2;
        default: wr_ptr <= wr_ptr;
      endcase
      if (pop_go) rd_ptr <= rd_ptr_p1;
      level      <= level_n;
      nonempty_q <= (level_n != '0);
      room1_q    <= room1_n;
      room2_q    <= room2_n;
    end
  end

endmodule

// File: rtl/dac_wr_fifo.sv
`timescale 1ns/1ps
// Write-side front end of a DAC controller: packs register writes into
// a small queue of (sample, channel) entries for the conversion sequencer.
module dac_wr_fifo
  import dac_wr_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CHAN_W   = 2,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned TAG_LSB  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_enable,
  input  logic                    cfg_word,
  input  logic                    cfg_tag,
  input  logic [CHAN_W-1:0]       cfg_chan,
  input  logic                    wr_en,
  input  logic [LANES*HALF_W-1:0] wr_data,
  output logic                    wr_ready,
  input  logic                    pop_en,
  output logic                    pop_valid,
  output logic [SAMPLE_W-1:0]     pop_sample,
  output logic [CHAN_W-1:0]       pop_chan
);

  localparam int unsigned ENT_W = CHAN_W + SAMPLE_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  xfer_e                  mode;
  logic [LANES*ENT_W-1:0] cand;
  logic [1:0]             push_n;
  logic                   accept;
  logic [ENT_W-1:0]       head;
  logic [CNT_W-1:0]       level;
  logic                   nonempty_q, room1_q, room2_q;

  assign mode = xfer_e'(cfg_word);

  dac_wr_split #(
    .HALF_W  (HALF_W),
    .SAMPLE_W(SAMPLE_W),
    .CHAN_W  (CHAN_W),
    .TAG_LSB (TAG_LSB),
    .LANES   (LANES),
    .ENT_W   (ENT_W)
  ) u_split (
    .wr_data (wr_data),
    .tag_mode(cfg_tag),
    .def_chan(cfg_chan),
    .entries (cand)
  );

  // Ready needs room for every entry the current mode would push.
  assign wr_ready = cfg_enable & ((mode == XFER_WORD) ? room2_q : room1_q);
  assign accept   = wr_en & wr_ready;

  always_comb begin
    if (!accept)                push_n = 2'd0;
    else if (mode == XFER_WORD) push_n = 2'd2;
    else                        push_n = 2'd1;
  end

  dac_wr_store #(
    .DEPTH(DEPTH),
    .ENT_W(ENT_W),
    .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .push_lo   (cand[0 +: ENT_W]),
    .push_hi   (cand[ENT_W +: ENT_W]),
    .pop       (pop_en),
    .head      (head),
    .level     (level),
    .nonempty_q(nonempty_q),
    .room1_q   (room1_q),
    .room2_q   (room2_q)
  );

  assign pop_valid  = nonempty_q;
  assign pop_sample = head[SAMPLE_W-1:0];
  assign pop_chan   = head[ENT_W-1 -: CHAN_W];

endmodule

// File: rtl/dac_wr_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for dac_wr_fifo, attached by bind below.
module dac_wr_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             cfg_word,
  input logic             wr_en,
  input logic             wr_ready,
  input logic             pop_en,
  input logic             pop_valid,
  input logic [CNT_W-1:0] level
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (level == '0) && !pop_valid);

  // R2
  half_push_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ready && !cfg_word && !(pop_en && pop_valid))
      |=> level == $past(level) + CNT_W'(1));

  // R3
  word_push_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ready && cfg_word && !(pop_en && pop_valid))
      |=> level == $past(level) + CNT_W'(2));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= int'(DEPTH));

  // R7
  word_room_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && cfg_word) |-> int'(level) + 2 <= int'(DEPTH));

  // R8
  idle_block_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> !wr_ready);

  // R8
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ready && !(pop_en && pop_valid)) |=> $stable(level));

  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_en && pop_valid && !(wr_en && wr_ready))
      |=> level == $past(level) - CNT_W'(1));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !pop_valid && !wr_en) |=> (level == '0) && !pop_valid);

endmodule

bind dac_wr_fifo dac_wr_fifo_chk #(
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_enable(cfg_enable),
  .cfg_word  (cfg_word),
  .wr_en     (wr_en),
  .wr_ready  (wr_ready),
  .pop_en    (pop_en),
  .pop_valid (pop_valid),
  .level     (level)
);

// File: tb/dac_wr_fifo_test.sv
`timescale 1ns/1ps
module dac_wr_fifo_test;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned ENT_W = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1;
  logic        cfg_word = 1'b0;
  logic        cfg_tag = 1'b0;
  logic [1:0]  cfg_chan = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        pop_en = 1'b0;
  logic        pop_valid;
  logic [11:0] pop_sample;
  logic [1:0]  pop_chan;

  int   checks = 0;
  int   fails  = 0;
  logic drain  = 1'b0;
  logic stray  = 1'b0;
  logic done   = 1'b0;
  logic [ENT_W-1:0] sb [$];
  logic [ENT_W-1:0] exp_e;

  always #10 clk = ~clk;

  dac_wr_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_word(cfg_word),
    .cfg_tag(cfg_tag), .cfg_chan(cfg_chan), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .pop_en(pop_en), .pop_valid(pop_valid),
    .pop_sample(pop_sample), .pop_chan(pop_chan)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected entry from the requirements: {channel, sample}.
  function automatic logic [ENT_W-1:0] model(input logic [15:0] half,
                                             input logic tag,
                                             input logic [1:0] dch);
    return {(tag ? half[13:12] : dch), half[11:0]};
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Driver: one write; scoreboard only what a ready write must store.
  task automatic put(input logic [31:0] d);
    @(negedge clk);
    #1;
    wr_en   = 1'b1;
    wr_data = d;
    if (wr_ready) begin
      sb.push_back(model(d[15:0], cfg_tag, cfg_chan));
      if (cfg_word) sb.push_back(model(d[31:16], cfg_tag, cfg_chan));
    end
    @(negedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic drain_all(input string req);
    drain = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      #2;
      if (sb.size() == 0 && !pop_valid) break;
    end
    check(req, pop_valid, 1'b0, "pop_valid after drain");
    check(req, sb.size(), 0, "expected entries never delivered");
    drain = 1'b0;
  endtask

  // Monitor: pops and compares against the scoreboard.
  always @(negedge clk) begin
    pop_en = stray;
    if (drain && pop_valid) begin
      pop_en = 1'b1;
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 unexpected entry: actual %0h expected none",
                 {pop_chan, pop_sample});
      end else begin
        exp_e = sb.pop_front();
        check("R6", {pop_chan, pop_sample}, exp_e, "popped entry in order");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    #2;
    // R1
    check("R1", pop_valid, 1'b0, "pop_valid after reset");
    check("R1", wr_ready, 1'b1, "wr_ready after reset");

    // R2 upper half ignored, R4 tag bits ignored when tagging off
    cfg_chan = 2'd2;
    put(32'hABCD_5123);
    check("R2", pop_valid, 1'b1, "entry present after half write");
    check("R2", pop_sample, 12'h123, "half-word sample");
    check("R4", pop_chan, 2'd2, "default channel despite tag bits 01");
    drain_all("R2");

    // R6 fill to DEPTH in half-word mode
    for (int i = 0; i < 4; i++) begin
      put(32'h0000_0100 + 32'(i));
      check("R6", wr_ready, (i < 3), "ready while filling");
    end
    // R8 write while not ready is discarded
    put(32'h0000_0EEE);
    check("R8", wr_ready, 1'b0, "ready stays low after dropped write");
    drain_all("R8");

    // R7 word mode needs two free slots
    cfg_chan = 2'd1;
    put(32'h0000_0AAA);
    cfg_word = 1'b1;
    #1 check("R7", wr_ready, 1'b1, "word ready with three free");
    put(32'h0BBB_0CCC);
    check("R7", wr_ready, 1'b0, "word not ready with one free");
    cfg_word = 1'b0;
    #1 check("R6", wr_ready, 1'b1, "half ready with one free");
    put(32'h0000_0DDD);
    check("R6", wr_ready, 1'b0, "half not ready when full");
    drain_all("R7");

    // R3 word order and R5 per-half tags
    cfg_word = 1'b1;
    cfg_tag  = 1'b1;
    cfg_chan = 2'd0;
    put(32'h1ABC_3123);
    check("R3", pop_sample, 12'h123, "low half leaves first");
    check("R5", pop_chan, 2'd3, "tag from bits 13:12");
    check("R7", wr_ready, 1'b1, "word ready with exactly two free");
    put(32'h2456_0789);
    check("R7", wr_ready, 1'b0, "word not ready when full");
    drain_all("R3");

    // R5 half-word tag overrides default
    cfg_word = 1'b0;
    cfg_chan = 2'd3;
    put(32'h0000_0321);
    check("R5", pop_chan, 2'd0, "tag 00 overrides default 3");
    drain_all("R5");

    // R9 channel fixed at push time
    cfg_tag  = 1'b0;
    cfg_chan = 2'd1;
    put(32'h0000_3456);
    cfg_tag  = 1'b1;
    cfg_chan = 2'd2;
    #1 check("R9", pop_chan, 2'd1, "channel after config change");
    drain_all("R9");
    cfg_tag = 1'b0;

    // R8 disabled controller
    cfg_enable = 1'b0;
    #1 check("R8", wr_ready, 1'b0, "ready low while disabled");
    put(32'h0000_0F0F);
    check("R8", pop_valid, 1'b0, "no entry stored while disabled");
    cfg_enable = 1'b1;

    // R10 pop on empty queue
    @(negedge clk);
    #1 stray = 1'b1;
    repeat (2) @(negedge clk);
    #1 stray = 1'b0;
    @(negedge clk);
    #2 check("R10", pop_valid, 1'b0, "empty after stray pops");
    put(32'h0000_0777);
    check("R10", pop_valid, 1'b1, "one entry after stray pops");
    drain_all("R10");

    // R10 streaming with simultaneous push and pop
    drain = 1'b1;
    for (int i = 0; i < 8; i++) put(32'h0000_0200 + 32'(i * 17));
    cfg_word = 1'b1;
    for (int i = 0; i < 4; i++) put({16'h0000 + 16'(i * 3 + 5), 16'h0000 + 16'(i * 11)});
    cfg_word = 1'b0;
    drain_all("R10");

    finish_run();
  end
endmodule